// File: doc/BRIEF.md
# Periodic-Interrupt Clock Core

This core keeps a free-running binary divider clocked by a 32.768 kHz tick enable and derives a programmable periodic interrupt from one of the divider's power-of-two taps. A four-bit rate code selects the tap. Code 15 gives 2 Hz, and each lower code doubles the frequency, so the period is 2^(code-1) ticks. Code 0 turns the interrupt off. Codes 1 and 2 are clamped to the shortest period the core supports, which is four ticks. The same divider marks the one-second boundary. Shortly before each boundary it raises a busy indication that software can poll to know that time values are in flux.

Software reaches the core through two byte-wide ports. A write to the selector port picks a register number. Later accesses on the data port act on the register that number names. Two registers are mapped. The control register holds the rate code, a fixed three-bit oscillator setting and the busy bit. The flag register holds the periodic flag and the combined interrupt flag. Reading the flag register clears it, and the interrupt pin remains asserted until that read happens.

Top module: `rtc_periodic_core`

## Requirements
- R1: After reset the selector holds 0, the control register (number 0x0A) reads 0x2D (busy bit 0, oscillator setting 3'b010 in bits 6:4, rate 4'b1101 in bits 3:0), the flag register (number 0x0C) reads 0x00 and `irq` is low.
- R2: A write with `port_sel`=0 stores `wdata` as the selector, and a read with `port_sel`=0 returns it. Accesses with `port_sel`=1 act on the register the selector names. Unmapped numbers read 0x00, and writes to them change no mapped register.
- R3: A data write while the selector is 0x0A replaces only the rate code (bits 3:0). Bits 7:4 of the written byte are discarded, so the register reads back {busy, 3'b010, new rate}.
- R4: With rate code r from 3 to 15, successive periodic events are exactly 2^(r-1) ticks apart.
- R5: Rate codes 1 and 2 give the same four-tick period as code 3.
- R6: Rate code 0 raises no periodic event, and `irq` stays low.
- R7: The flag register carries the periodic flag in bit 6 and the combined interrupt flag in bit 7, with bits 5:0 always 0. A data read while the selector is 0x0C returns the flags and clears both of them on that clock edge.
- R8: `irq` equals the combined flag. Once set it stays high across any number of further periods until the flag register is read, and it falls on the edge of that read.
- R9: If a periodic event falls on the same edge as the clearing read, the flags are set again, and `irq` stays high.
- R10: The busy bit (control register bit 7) is high for exactly 244 ticks ending at each one-second rollover (32768 ticks) and low for the other 32524 ticks. It falls on the rollover edge.
- R11: The divider advances only on cycles with `tick_en` high. While `tick_en` is low, no periodic event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| port_sel | input | 1 | 0 selects the selector port, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the addressed port |
| rd_en | input | 1 | Read strobe for the addressed port (causes the clear-on-read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port, valid in the cycle the read is strobed |
| irq | output | 1 | Level interrupt, high while the combined flag is set |

## Verification
The assertions assume that each host strobe lasts a single clock cycle, and that `tick_en` is a clean synchronous enable, which the clearing-read and rollover properties need so they can relate one edge to the next. The stimulus drives all strobes and the tick enable on falling edges, one cycle at a time. It keeps `tick_en` high on every cycle except in the gating test, so the bench can predict event edges from the first observed rise of `irq` and place a clearing read exactly on, or just off, an event edge. Period, clamp and busy-window lengths are computed in the bench from the rate code and the 32768-tick second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RATE_W = 4;

  typedef struct packed {
    logic              busy;
    logic [2:0]        osc_cfg;
    logic [RATE_W-1:0] rate;
  } ctrl_reg_t;

  typedef struct packed {
    logic       any_flag;
    logic       per_flag;
    logic [5:0] zero;
  } flag_reg_t;

  // Divider tap (log2 of period in ticks) chosen by a rate code.
  function automatic int unsigned rate_shift(input logic [RATE_W-1:0] code,
                                             input int unsigned lo,
                                             input int unsigned hi);
    int unsigned s;
    s = int'(code);
    if (s > 0) s = s - 1;
    if (s < lo) s = lo;
    if (s > hi) s = hi;
    return s;
  endfunction

  function automatic logic rate_active(input logic [RATE_W-1:0] code);
    return code != '0;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctrl(input logic busy,
                                                  input logic [2:0] osc,
                                                  input logic [RATE_W-1:0] code);
    ctrl_reg_t r;
    r.busy    = busy;
    r.osc_cfg = osc;
    r.rate    = code;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_flags(input logic any_f,
                                                   input logic per_f);
    flag_reg_t r;
    r.any_flag = any_f;
    r.per_flag = per_f;
    r.zero     = '0;
    return r;
  endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned DIV_BITS  = 15,
  parameter int unsigned UIP_TICKS = 244,
  parameter int unsigned MIN_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  input  logic [rtc_pkg::RATE_W-1:0] rate,
  output logic                      periodic_evt,
  output logic                      second_roll,
  output logic                      busy
);
  localparam int unsigned MAX_SHIFT = DIV_BITS - 1;
  localparam int unsigned SH_W      = $clog2(MAX_SHIFT + 1);
  localparam longint unsigned FULL  = 64'd1 << DIV_BITS;
  localparam logic [DIV_BITS-1:0] BUSY_START = DIV_BITS'(FULL - UIP_TICKS);

  logic [DIV_BITS-1:0]  cnt_q;
  logic [MAX_SHIFT:0]   tap_hit;
  logic [SH_W-1:0]      shift_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  // One tap per power of two: tap s fires when the low s bits are all ones.
  assign tap_hit[0] = 1'b1;
  for (genvar s = 1; s <= MAX_SHIFT; s++) begin : g_tap
    assign tap_hit[s] = &cnt_q[s-1:0];
  end

  assign shift_sel    = SH_W'(rtc_pkg::rate_shift(rate, MIN_SHIFT, MAX_SHIFT));
  assign periodic_evt = tick_en && rtc_pkg::rate_active(rate) && tap_hit[shift_sel];
  assign second_roll  = tick_en && (&cnt_q);
  assign busy         = (cnt_q >= BUSY_START);

  a_r10_busy_falls_at_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(second_roll));

  a_r10_busy_rises_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick_en));

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port #(
  parameter logic [7:0] IDX_CTRL   = 8'h0A,
  parameter logic [7:0] IDX_FLAGS  = 8'h0C,
  parameter logic [3:0] RESET_RATE = 4'hD,
  parameter logic [2:0] OSC_CFG    = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic [7:0] flag_image,
  output logic [7:0] rdata,
  output logic [3:0] rate,
  output logic       flags_read
);
  logic [7:0] sel_q;
  logic [3:0] rate_q;
  logic       sel_wr;
  logic       data_wr;
  logic       data_rd;
  logic       ctrl_wr;

  assign sel_wr     = wr_en && !port_sel;
  assign data_wr    = wr_en && port_sel;
  assign data_rd    = rd_en && port_sel;
  assign ctrl_wr    = data_wr && (sel_q == IDX_CTRL);
  assign flags_read = data_rd && (sel_q == IDX_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rate_q <= RESET_RATE;
    end else begin
      if (sel_wr)  sel_q  <= wdata;
      if (ctrl_wr) rate_q <= wdata[3:0];
    end
  end

  always_comb begin
    if (!port_sel) begin
      rdata = sel_q;
    end else begin
      unique case (sel_q)
        IDX_CTRL:  rdata = rtc_pkg::pack_ctrl(busy, OSC_CFG, rate_q);
        IDX_FLAGS: rdata = flag_image;
        default:   rdata = '0;
      endcase
    end
  end

  assign rate = rate_q;

  a_r2_selector_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(wdata));

  a_r2_selector_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> sel_q == $past(sel_q));

  a_r3_rate_only_by_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> rate_q == $past(rate_q));

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periodic_evt,
  input  logic       flags_read,
  output logic [7:0] flag_image,
  output logic       irq
);
  logic per_q;
  logic any_flag;

  // A read clears; an event on the same edge wins and sets the flag again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= 1'b0;
    else        per_q <= (per_q && !flags_read) || periodic_evt;
  end

  assign any_flag   = per_q;
  assign flag_image = rtc_pkg::pack_flags(any_flag, per_q);
  assign irq        = any_flag;

  a_r8_flag_holds_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    per_q && !flags_read |=> per_q);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flags_read && !periodic_evt |=> !irq);

  a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flags_read && periodic_evt |=> irq);

  a_r8_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(periodic_evt));

endmodule

// File: rtl/rtc_periodic_core.sv
module rtc_periodic_core #(
  parameter int unsigned DIV_BITS   = 15,
  parameter int unsigned UIP_TICKS  = 244,
  parameter int unsigned MIN_SHIFT  = 2,
  parameter logic [7:0]  IDX_CTRL   = 8'h0A,
  parameter logic [7:0]  IDX_FLAGS  = 8'h0C,
  parameter logic [3:0]  RESET_RATE = 4'hD,
  parameter logic [2:0]  OSC_CFG    = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic [3:0] rate;
  logic       periodic_evt;
  logic       second_roll;
  logic       busy;
  logic [7:0] flag_image;
  logic       flags_read;

  rtc_divider #(
    .DIV_BITS (DIV_BITS),
    .UIP_TICKS(UIP_TICKS),
    .MIN_SHIFT(MIN_SHIFT)
  ) div_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .rate        (rate),
    .periodic_evt(periodic_evt),
    .second_roll (second_roll),
    .busy        (busy)
  );

  rtc_host_port #(
    .IDX_CTRL  (IDX_CTRL),
    .IDX_FLAGS (IDX_FLAGS),
    .RESET_RATE(RESET_RATE),
    .OSC_CFG   (OSC_CFG)
  ) host_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .busy      (busy),
    .flag_image(flag_image),
    .rdata     (rdata),
    .rate      (rate),
    .flags_read(flags_read)
  );

  rtc_irq_flags flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .periodic_evt(periodic_evt),
    .flags_read  (flags_read),
    .flag_image  (flag_image),
    .irq         (irq)
  );

  a_r6_rate_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |-> !periodic_evt);

  a_r11_no_event_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !periodic_evt);

  a_r10_busy_clear_after_roll: assert property (@(posedge clk) disable iff (!rst_n)
    second_roll |=> !busy);

endmodule

// File: tb/rtc_periodic_core_tb.sv
module rtc_periodic_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       port_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] SEL_CTRL  = 8'h0A;
  localparam logic [7:0] SEL_FLAGS = 8'h0C;

  always #10 clk = ~clk;

  rtc_periodic_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .port_sel(port_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sel_write(input logic [7:0] v);
    @(negedge clk);
    port_sel = 1'b0; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] v);
    @(negedge clk);
    port_sel = 1'b1; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Read strobed in the current cycle; returns at the next falling edge.
  task automatic read_now(input logic ps, output logic [7:0] v);
    port_sel = ps; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic port_read(input logic ps, output logic [7:0] v);
    @(negedge clk);
    read_now(ps, v);
  endtask

  task automatic wait_irq();
    while (irq !== 1'b1) @(negedge clk);
  endtask

  task automatic set_rate(input logic [7:0] code_byte);
    sel_write(SEL_CTRL);
    data_write(code_byte);
    sel_write(SEL_FLAGS);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    int hi_len;
    int lo_len;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", int'(irq), 0);
    port_read(1'b0, v); chk("R1 selector reset", v, 8'h00);
    sel_write(SEL_CTRL);
    port_read(1'b1, v); chk("R1 control reset", v, 8'h2D);
    sel_write(SEL_FLAGS);
    port_read(1'b1, v); chk("R1 flags reset", v, 8'h00);

    // R2 selector and unmapped numbers
    sel_write(8'h0B);
    port_read(1'b0, v); chk("R2 selector readback", v, 8'h0B);
    data_write(8'hFF);
    port_read(1'b1, v); chk("R2 unmapped reads zero", v, 8'h00);
    sel_write(SEL_CTRL);
    port_read(1'b1, v); chk("R2 unmapped write left control", v, 8'h2D);
    port_read(1'b1, v); chk("R2 selector persists", v, 8'h2D);

    // R3 only the rate nibble is stored
    data_write(8'hF7);
    port_read(1'b1, v); chk("R3 control after write", v, 8'h27);
    data_write(8'h03);
    port_read(1'b1, v); chk("R3 osc bits kept", v, 8'h23);

    // R9 event on the clearing edge: rate 3, period 4
    sel_write(SEL_FLAGS);
    port_read(1'b1, v);
    wait_irq();
    repeat (3) @(negedge clk);
    read_now(1'b1, v);
    chk("R7 flag image when set", v, 8'hC0);
    chk("R9 flag set again on coincident event", int'(irq), 1);
    read_now(1'b1, v);
    chk("R9 later read clears", int'(irq), 0);

    // R8 level held across periods, cleared by the read
    wait_irq();
    repeat (10) @(negedge clk);
    chk("R8 irq held without read", int'(irq), 1);
    read_now(1'b1, v);
    chk("R8 flags before clear", v, 8'hC0);
    chk("R8 irq drops after read", int'(irq), 0);
    read_now(1'b1, v);
    chk("R7 flags read zero after clear", v, 8'h00);

    // R11 tick gating
    @(negedge clk);
    tick_en = 1'b0;
    read_now(1'b1, v);
    repeat (50) @(negedge clk);
    chk("R11 no event while ticks stopped", int'(irq), 0);
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 event resumes with ticks", int'(irq), 1);

    // R6 rate zero
    set_rate(8'h00);
    port_read(1'b1, v);
    repeat (200) @(negedge clk);
    chk("R6 no irq at rate 0", int'(irq), 0);

    // R4/R5 period sweep
    for (int r = 1; r <= 15; r++) begin
      int exp_p;
      exp_p = (r <= 2) ? 4 : (1 << (r - 1));
      set_rate(8'(r));
      port_read(1'b1, v);
      wait_irq();
      read_now(1'b1, v);
      cnt = 1;
      while (irq !== 1'b1) begin
        @(negedge clk);
        cnt++;
      end
      if (r <= 2) chk($sformatf("R5 clamped period rate %0d", r), cnt, exp_p);
      else        chk($sformatf("R4 period rate %0d", r), cnt, exp_p);
    end

    // R10 busy window length
    sel_write(SEL_CTRL);
    port_sel = 1'b1;
    #1;
    while (rdata[7] === 1'b1) begin @(negedge clk); #1; end
    while (rdata[7] !== 1'b1) begin @(negedge clk); #1; end
    hi_len = 0;
    while (rdata[7] === 1'b1) begin hi_len++; @(negedge clk); #1; end
    lo_len = 0;
    while (rdata[7] !== 1'b1) begin lo_len++; @(negedge clk); #1; end
    chk("R10 busy high ticks", hi_len, 244);
    chk("R10 busy low ticks", lo_len, 32768 - 244);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule